// File: doc/BRIEF.md
# Hex Command Line Bus Bridge

This block turns short ASCII command lines into transactions on a plain address/data bus and reports each outcome back as ASCII text. Bytes arrive one at a time on a receive byte port, usually fed by a UART receiver. Replies leave one byte at a time on a transmit byte port that has a ready input, usually feeding a UART transmitter. The bit-level serialisers are not part of the block.

A line with one hexadecimal token reads the bus at that address. A line with two tokens, address first and data second, writes the bus. Each request waits for its ready input. Reads and writes each have their own timeout window. A parameter chooses whether read data is taken in the cycle where read-ready is high or in the cycle after it. A host can use the bridge to inspect and modify registers or memory through a terminal.

Top module: `hexbus_bridge`

## Requirements
- R1: A line holding one hex token and ending in newline (0x0A) raises `rd_req` with `rd_addr` equal to that token. For example, "12\n" reads address 0x12.
- R2: A line holding two tokens separated by a space (0x20) raises `wr_req` with `wr_addr` equal to the first token and `wr_data` equal to the second. For example, "12 deadbeef\n" writes 0xDEADBEEF to address 0x12.
- R3: Hex digits are accepted in upper and lower case. Each digit shifts the field left by four bits, and a token longer than its field keeps only its low bits. A carriage return (0x0D) acts as a separator, like a space.
- R4: A line that holds any other character, holds no token, or holds more than two tokens starts no bus transaction. The reply to such a line is "error\n".
- R5: A request stays high until its ready input is seen and drops in the next cycle. Its address and data do not change while it is high. Read and write requests are never high together.
- R6: A read request is high for at most `RD_WAIT` cycles and a write request for at most `WR_WAIT` cycles. A ready that arrives in the last allowed cycle counts as success. A request that expires gets the reply "timeout\n".
- R7: With `RD_SAME_CYCLE`=1, read data is taken in the cycle where `rd_ack` is high. With `RD_SAME_CYCLE`=0, it is taken in the following cycle.
- R8: A successful read replies with 2*`DATA_BYTES` uppercase hex digits, most significant first, then "\n". A successful write replies "ok\n".
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_byte` holds its value.
- R10: Bytes that arrive from the cycle after a newline until the last reply byte has been taken are dropped. They cause no transaction and no reply.
- R11: After reset, `rd_req`, `wr_req` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Incoming byte present this cycle |
| rx_byte | input | 8 | Incoming ASCII byte |
| tx_valid | output | 1 | Reply byte present |
| tx_byte | output | 8 | Reply ASCII byte |
| tx_ready | input | 1 | Sink takes the reply byte this cycle |
| rd_req | output | 1 | Read request |
| rd_ack | input | 1 | Read ready |
| rd_addr | output | 8*ADDR_BYTES | Read address |
| rd_data | input | 8*DATA_BYTES | Read data |
| wr_req | output | 1 | Write request |
| wr_ack | input | 1 | Write ready |
| wr_addr | output | 8*ADDR_BYTES | Write address |
| wr_data | output | 8*DATA_BYTES | Write data |

## Verification
The close case is a ready that arrives in the same cycle the timeout window ends. In that cycle the success path and the expiry path are both live, and success must win. The bench's bus responder raises ready on exactly the last allowed cycle, and the check passes only if the reply carries data or "ok" rather than "timeout". A second pairing is a new byte that lands in the cycle where a command is handed off. The bench sends a second line straight after a newline, and the check passes only if that line produces no transaction and no reply.

// File: rtl/hb_pkg.sv
// Shared command and reply codes for the hex command bridge.
package hb_pkg;
    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_BAD   = 2'd2
    } hb_cmd_e;

    typedef enum logic [1:0] {
        REP_DATA = 2'd0,
        REP_OK   = 2'd1,
        REP_TMO  = 2'd2,
        REP_ERR  = 2'd3
    } hb_rep_e;
endpackage

// File: rtl/hb_line_parser.sv
// Line parser: builds address and data fields from hex tokens and,
// on newline, emits a one-cycle command of kind read, write or bad.
// Assumes the caller gates byte_valid while a command is in flight,
// so the field outputs stay stable until the command is finished.
module hb_line_parser
    import hb_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int DATA_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_valid,
    input  logic [7:0]              byte_in,
    output logic                    cmd_valid,
    output hb_cmd_e                 cmd_kind,
    output logic [ADDR_BYTES*8-1:0] cmd_addr,
    output logic [DATA_BYTES*8-1:0] cmd_data
);
    localparam int AW = ADDR_BYTES * 8;
    localparam int DW = DATA_BYTES * 8;

    logic       is_hex, is_sep, is_eol;
    logic [3:0] nib;
    logic [1:0] tok_cnt;
    logic       in_tok;
    logic       bad;
    logic [1:0] tok_idx;

    // Classify the incoming character and produce its nibble value.
    always_comb begin
        is_hex = 1'b0;
        nib    = 4'd0;
        if (byte_in >= "0" && byte_in <= "9") begin
            is_hex = 1'b1;
            nib    = 4'(byte_in - "0");
        end else if (byte_in >= "a" && byte_in <= "f") begin
            is_hex = 1'b1;
            nib    = 4'(byte_in - "a" + 8'd10);
        end else if (byte_in >= "A" && byte_in <= "F") begin
            is_hex = 1'b1;
            nib    = 4'(byte_in - "A" + 8'd10);
        end
        is_sep  = (byte_in == 8'h20) || (byte_in == 8'h0D);
        is_eol  = (byte_in == 8'h0A);
        tok_idx = in_tok ? tok_cnt : ((tok_cnt == 2'd3) ? 2'd3 : tok_cnt + 2'd1);
    end

    // Token accumulation and end-of-line command decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_kind  <= CMD_BAD;
            cmd_addr  <= '0;
            cmd_data  <= '0;
            tok_cnt   <= 2'd0;
            in_tok    <= 1'b0;
            bad       <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (byte_valid) begin
                if (is_eol) begin
                    cmd_valid <= 1'b1;
                    if (bad || tok_cnt == 2'd0 || tok_cnt == 2'd3)
                        cmd_kind <= CMD_BAD;
                    else if (tok_cnt == 2'd1)
                        cmd_kind <= CMD_READ;
                    else
                        cmd_kind <= CMD_WRITE;
                    tok_cnt <= 2'd0;
                    in_tok  <= 1'b0;
                    bad     <= 1'b0;
                end else if (is_sep) begin
                    in_tok <= 1'b0;
                end else if (is_hex) begin
                    in_tok  <= 1'b1;
                    tok_cnt <= tok_idx;
                    if (tok_idx == 2'd1)
                        cmd_addr <= in_tok ? {cmd_addr[AW-5:0], nib} : {{(AW-4){1'b0}}, nib};
                    else if (tok_idx == 2'd2)
                        cmd_data <= in_tok ? {cmd_data[DW-5:0], nib} : {{(DW-4){1'b0}}, nib};
                    else
                        bad <= 1'b1;
                end else begin
                    bad <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hb_bus_engine.sv
// Bus engine: holds one read or write request until ready or until its
// direction's wait window runs out, then reports the outcome once.
// Assumes start only arrives while idle.
module hb_bus_engine
    import hb_pkg::*;
#(
    parameter int ADDR_BYTES    = 4,
    parameter int DATA_BYTES    = 4,
    parameter int WR_WAIT       = 500,
    parameter int RD_WAIT       = 500,
    parameter bit RD_SAME_CYCLE = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  hb_cmd_e                 start_kind,
    input  logic [ADDR_BYTES*8-1:0] start_addr,
    input  logic [DATA_BYTES*8-1:0] start_data,
    output logic                    rd_req,
    input  logic                    rd_ack,
    output logic [ADDR_BYTES*8-1:0] rd_addr,
    input  logic [DATA_BYTES*8-1:0] rd_data,
    output logic                    wr_req,
    input  logic                    wr_ack,
    output logic [ADDR_BYTES*8-1:0] wr_addr,
    output logic [DATA_BYTES*8-1:0] wr_data,
    output logic                    done,
    output hb_rep_e                 done_res,
    output logic [DATA_BYTES*8-1:0] done_data
);
    localparam int MAXW = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
    localparam int TW   = $clog2(MAXW + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_RCAP, ST_WR} eng_st_e;
    eng_st_e       st;
    logic [TW-1:0] timer;

    // Request sequencing, wait-window count and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            timer     <= '0;
            rd_req    <= 1'b0;
            wr_req    <= 1'b0;
            rd_addr   <= '0;
            wr_addr   <= '0;
            wr_data   <= '0;
            done      <= 1'b0;
            done_res  <= REP_OK;
            done_data <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    timer <= '0;
                    if (start && start_kind == CMD_READ) begin
                        st      <= ST_RD;
                        rd_req  <= 1'b1;
                        rd_addr <= start_addr;
                    end else if (start && start_kind == CMD_WRITE) begin
                        st      <= ST_WR;
                        wr_req  <= 1'b1;
                        wr_addr <= start_addr;
                        wr_data <= start_data;
                    end
                end
                ST_RD: begin
                    if (rd_ack) begin
                        rd_req <= 1'b0;
                        if (RD_SAME_CYCLE) begin
                            st        <= ST_IDLE;
                            done      <= 1'b1;
                            done_res  <= REP_DATA;
                            done_data <= rd_data;
                        end else begin
                            st <= ST_RCAP;
                        end
                    end else if (timer == TW'(RD_WAIT - 1)) begin
                        rd_req   <= 1'b0;
                        st       <= ST_IDLE;
                        done     <= 1'b1;
                        done_res <= REP_TMO;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                ST_RCAP: begin
                    st        <= ST_IDLE;
                    done      <= 1'b1;
                    done_res  <= REP_DATA;
                    done_data <= rd_data;
                end
                ST_WR: begin
                    if (wr_ack) begin
                        wr_req   <= 1'b0;
                        st       <= ST_IDLE;
                        done     <= 1'b1;
                        done_res <= REP_OK;
                    end else if (timer == TW'(WR_WAIT - 1)) begin
                        wr_req   <= 1'b0;
                        st       <= ST_IDLE;
                        done     <= 1'b1;
                        done_res <= REP_TMO;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Checker counters: length of the current request-high run.
    logic [TW:0] rd_run, wr_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_run <= '0;
            wr_run <= '0;
        end else begin
            rd_run <= rd_req ? rd_run + 1'b1 : '0;
            wr_run <= wr_req ? wr_run + 1'b1 : '0;
        end
    end

    p_one_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
    p_rd_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |=> !rd_req);
    p_wr_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> !wr_req);
    p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> $stable(rd_addr));
    p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> ($stable(wr_addr) && $stable(wr_data)));
    p_rd_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_run < (TW+1)'(RD_WAIT)));
    p_wr_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_run < (TW+1)'(WR_WAIT)));
endmodule

// File: rtl/hb_reply_gen.sv
// Reply generator: streams one ASCII reply ("ok", "timeout", "error"
// or a hex data word, each ending in newline) over a valid/ready port.
// Assumes start only arrives while no reply is being sent.
module hb_reply_gen
    import hb_pkg::*;
#(
    parameter int DATA_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  hb_rep_e                 code,
    input  logic [DATA_BYTES*8-1:0] value,
    output logic                    tx_valid,
    output logic [7:0]              tx_byte,
    input  logic                    tx_ready,
    output logic                    done
);
    localparam int DW     = DATA_BYTES * 8;
    localparam int NDIG   = 2 * DATA_BYTES;
    localparam int MAXLEN = (NDIG + 1 > 8) ? NDIG + 1 : 8;
    localparam int IW     = $clog2(MAXLEN + 1);

    logic [IW-1:0] idx;
    hb_rep_e       code_q;
    logic [DW-1:0] val_q;
    logic          active;

    function automatic logic [IW-1:0] rep_len(hb_rep_e c);
        case (c)
            REP_DATA: rep_len = IW'(NDIG + 1);
            REP_OK:   rep_len = IW'(3);
            REP_TMO:  rep_len = IW'(8);
            default:  rep_len = IW'(6);
        endcase
    endfunction

    function automatic logic [7:0] rep_char(hb_rep_e c, logic [IW-1:0] i, logic [DW-1:0] v);
        logic [DW-1:0] sh;
        logic [3:0]    n;
        int            ii;
        ii = int'(i);
        sh = '0;
        n  = 4'd0;
        rep_char = 8'h0A;
        case (c)
            REP_DATA: if (ii < NDIG) begin
                sh = v >> ((NDIG - 1 - ii) * 4);
                n  = sh[3:0];
                rep_char = (n < 4'd10) ? (8'h30 + {4'd0, n}) : (8'h37 + {4'd0, n});
            end
            REP_OK: case (ii)
                0: rep_char = "o";
                1: rep_char = "k";
                default: rep_char = 8'h0A;
            endcase
            REP_TMO: case (ii)
                0: rep_char = "t";
                1: rep_char = "i";
                2: rep_char = "m";
                3: rep_char = "e";
                4: rep_char = "o";
                5: rep_char = "u";
                6: rep_char = "t";
                default: rep_char = 8'h0A;
            endcase
            default: case (ii)
                0: rep_char = "e";
                1: rep_char = "r";
                2: rep_char = "r";
                3: rep_char = "o";
                4: rep_char = "r";
                default: rep_char = 8'h0A;
            endcase
        endcase
    endfunction

    // Output byte comes straight from the latched reply and position.
    always_comb begin
        tx_valid = active;
        tx_byte  = rep_char(code_q, idx, val_q);
    end

    // Position advance on each accepted byte; done after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            code_q <= REP_OK;
            val_q  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                idx    <= '0;
                code_q <= code;
                val_q  <= value;
            end else if (active && tx_ready) begin
                if (idx == rep_len(code_q) - 1'b1) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
endmodule

// File: rtl/hexbus_bridge.sv
// Hex command bridge top: parser -> bus engine -> reply generator.
// A command is in flight from the cycle its newline is decoded until
// its last reply byte is taken; incoming bytes are dropped meanwhile.
module hexbus_bridge
    import hb_pkg::*;
#(
    parameter int ADDR_BYTES    = 4,
    parameter int DATA_BYTES    = 4,
    parameter int WR_WAIT       = 500,
    parameter int RD_WAIT       = 500,
    parameter bit RD_SAME_CYCLE = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_byte,
    output logic                    tx_valid,
    output logic [7:0]              tx_byte,
    input  logic                    tx_ready,
    output logic                    rd_req,
    input  logic                    rd_ack,
    output logic [ADDR_BYTES*8-1:0] rd_addr,
    input  logic [DATA_BYTES*8-1:0] rd_data,
    output logic                    wr_req,
    input  logic                    wr_ack,
    output logic [ADDR_BYTES*8-1:0] wr_addr,
    output logic [DATA_BYTES*8-1:0] wr_data
);
    logic                    busy;
    logic                    cmd_valid;
    hb_cmd_e                 cmd_kind;
    logic [ADDR_BYTES*8-1:0] cmd_addr;
    logic [DATA_BYTES*8-1:0] cmd_data;
    logic                    eng_done;
    hb_rep_e                 eng_res;
    logic [DATA_BYTES*8-1:0] eng_data;
    logic                    rep_start, rep_done;
    hb_rep_e                 rep_code;
    logic                    take_byte, eng_start;

    // Route commands: bad lines go straight to the reply path.
    always_comb begin
        take_byte = rx_valid && !busy && !cmd_valid;
        eng_start = cmd_valid && (cmd_kind != CMD_BAD);
        rep_start = (cmd_valid && cmd_kind == CMD_BAD) || eng_done;
        rep_code  = eng_done ? eng_res : REP_ERR;
    end

    // Busy flag spans one command from decode to final reply byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (cmd_valid)
            busy <= 1'b1;
        else if (rep_done)
            busy <= 1'b0;
    end

    hb_line_parser #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES)) u_parse (
        .clk(clk), .rst_n(rst_n), .byte_valid(take_byte), .byte_in(rx_byte),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    hb_bus_engine #(
        .ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES),
        .WR_WAIT(WR_WAIT), .RD_WAIT(RD_WAIT), .RD_SAME_CYCLE(RD_SAME_CYCLE)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .start_kind(cmd_kind),
        .start_addr(cmd_addr), .start_data(cmd_data),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(eng_done), .done_res(eng_res), .done_data(eng_data)
    );

    hb_reply_gen #(.DATA_BYTES(DATA_BYTES)) u_rep (
        .clk(clk), .rst_n(rst_n), .start(rep_start), .code(rep_code), .value(eng_data),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready), .done(rep_done)
    );

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !busy);
    p_bad_no_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_BAD) |=> (!rd_req && !wr_req));
    p_idle_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_valid);
endmodule

// File: tb/sim_hexbus_bridge.sv
// Scoreboard bench: u0 takes read data one cycle after ready, u1 in the
// ready cycle. Both see the same byte stream and a bus responder each.
module sim_hexbus_bridge;
    localparam int WRW = 20;
    localparam int RDW = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic tx_ready = 1'b1;
    logic        tx_valid_s [2];
    logic [7:0]  tx_byte_s  [2];
    logic        rd_req_s   [2];
    logic        rd_ack_s   [2];
    logic [31:0] rd_addr_s  [2];
    logic [31:0] rd_data_s  [2];
    logic        wr_req_s   [2];
    logic        wr_ack_s   [2];
    logic [31:0] wr_addr_s  [2];
    logic [31:0] wr_data_s  [2];

    always #5 clk = ~clk;

    hexbus_bridge #(.WR_WAIT(WRW), .RD_WAIT(RDW), .RD_SAME_CYCLE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_valid(tx_valid_s[0]), .tx_byte(tx_byte_s[0]), .tx_ready(tx_ready),
        .rd_req(rd_req_s[0]), .rd_ack(rd_ack_s[0]), .rd_addr(rd_addr_s[0]), .rd_data(rd_data_s[0]),
        .wr_req(wr_req_s[0]), .wr_ack(wr_ack_s[0]), .wr_addr(wr_addr_s[0]), .wr_data(wr_data_s[0]));

    hexbus_bridge #(.WR_WAIT(WRW), .RD_WAIT(RDW), .RD_SAME_CYCLE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_valid(tx_valid_s[1]), .tx_byte(tx_byte_s[1]), .tx_ready(tx_ready),
        .rd_req(rd_req_s[1]), .rd_ack(rd_ack_s[1]), .rd_addr(rd_addr_s[1]), .rd_data(rd_data_s[1]),
        .wr_req(wr_req_s[1]), .wr_ack(wr_ack_s[1]), .wr_addr(wr_addr_s[1]), .wr_data(wr_data_s[1]));

    int checks = 0;
    int fails = 0;

    task automatic check(bit ok, string tag, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // ---------------- bus responders ----------------
    int lat = 0;
    bit noack = 1'b0;
    logic [31:0] dA = 32'h0;
    logic [31:0] dB = 32'h0;
    int rcnt [2] = '{0, 0};
    int wcnt [2] = '{0, 0};
    bit prev_r [2] = '{0, 0};
    bit prev_w [2] = '{0, 0};
    int rd_txn [2] = '{0, 0};
    int wr_txn [2] = '{0, 0};
    int rd_cyc [2] = '{0, 0};
    int wr_cyc [2] = '{0, 0};
    logic [31:0] raddr_seen [2];
    logic [31:0] waddr_seen [2];
    logic [31:0] wdata_seen [2];

    initial begin
        for (int i = 0; i < 2; i++) begin
            rd_ack_s[i] = 1'b0; wr_ack_s[i] = 1'b0; rd_data_s[i] = 32'h0BADF00D;
            raddr_seen[i] = '0; waddr_seen[i] = '0; wdata_seen[i] = '0;
        end
    end

    // Each responder raises ready after lat request cycles; read data is
    // dA in the ready cycle and dB in the cycle after it.
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (rst_n && rd_req_s[i]) begin
                if (!prev_r[i]) rd_txn[i]++;
                rd_cyc[i]++;
                if (!noack && rcnt[i] == lat) begin
                    rd_ack_s[i] = 1'b1; rd_data_s[i] = dA; raddr_seen[i] = rd_addr_s[i];
                end else begin
                    rd_ack_s[i] = 1'b0; rd_data_s[i] = 32'h0BADF00D;
                end
                rcnt[i]++;
            end else begin
                rd_data_s[i] = rd_ack_s[i] ? dB : 32'h0BADF00D;
                rd_ack_s[i] = 1'b0;
                rcnt[i] = 0;
            end
            prev_r[i] = rst_n && rd_req_s[i];
            if (rst_n && wr_req_s[i]) begin
                if (!prev_w[i]) wr_txn[i]++;
                wr_cyc[i]++;
                if (!noack && wcnt[i] == lat) begin
                    wr_ack_s[i] = 1'b1; waddr_seen[i] = wr_addr_s[i]; wdata_seen[i] = wr_data_s[i];
                end else begin
                    wr_ack_s[i] = 1'b0;
                end
                wcnt[i]++;
            end else begin
                wr_ack_s[i] = 1'b0;
                wcnt[i] = 0;
            end
            prev_w[i] = rst_n && wr_req_s[i];
        end
    end

    // ---------------- scoreboard ----------------
    logic [7:0] exp_q0 [$];
    logic [7:0] exp_q1 [$];
    string tag_q0 [$];
    string tag_q1 [$];

    task automatic push_str(int which, string s, string tag);
        for (int i = 0; i < s.len(); i++) begin
            if (which != 1) begin exp_q0.push_back(s[i]); tag_q0.push_back(tag); end
            if (which != 0) begin exp_q1.push_back(s[i]); tag_q1.push_back(tag); end
        end
    endtask

    function automatic string hexs(logic [31:0] v);
        string s;
        logic [3:0] n;
        s = "";
        for (int i = 7; i >= 0; i--) begin
            n = v[i*4 +: 4];
            s = $sformatf("%s%c", s, (n < 10) ? (8'h30 + n) : (8'h37 + n));
        end
        return {s, "\n"};
    endfunction

    bit held [2] = '{0, 0};
    logic [7:0] held_b [2];

    // Monitor: pop and compare accepted bytes; check held bytes (R9).
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                if (held[i]) begin
                    check(tx_valid_s[i] && tx_byte_s[i] == held_b[i], "R9 byte held under backpressure",
                          tx_byte_s[i], held_b[i]);
                end
                held[i] = tx_valid_s[i] && !tx_ready;
                held_b[i] = tx_byte_s[i];
            end
            if (tx_valid_s[0] && tx_ready) begin
                if (exp_q0.size() == 0) check(1'b0, "R10 u0 unexpected reply byte", tx_byte_s[0], 0);
                else begin
                    logic [7:0] e; string t;
                    e = exp_q0.pop_front(); t = tag_q0.pop_front();
                    check(tx_byte_s[0] == e, {"u0 ", t}, tx_byte_s[0], e);
                end
            end
            if (tx_valid_s[1] && tx_ready) begin
                if (exp_q1.size() == 0) check(1'b0, "R10 u1 unexpected reply byte", tx_byte_s[1], 0);
                else begin
                    logic [7:0] e; string t;
                    e = exp_q1.pop_front(); t = tag_q1.pop_front();
                    check(tx_byte_s[1] == e, {"u1 ", t}, tx_byte_s[1], e);
                end
            end
        end
    end

    bit toggle_ready = 1'b0;
    always @(negedge clk) begin
        if (toggle_ready) tx_ready = ~tx_ready;
    end

    // ---------------- driver ----------------
    task automatic send_line(string s);
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte = s[i];
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while ((exp_q0.size() != 0 || exp_q1.size() != 0) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (6) @(negedge clk);
        check(exp_q0.size() == 0 && exp_q1.size() == 0, "reply completed",
              exp_q0.size() + exp_q1.size(), 0);
    endtask

    function automatic void clr_cycles();
        for (int i = 0; i < 2; i++) begin rd_cyc[i] = 0; wr_cyc[i] = 0; end
    endfunction

    initial begin
        int r0, w0;
        repeat (4) @(negedge clk);
        // R11: reset state
        check(!tx_valid_s[0] && !tx_valid_s[1], "R11 tx_valid low in reset", tx_valid_s[0], 0);
        check(!rd_req_s[0] && !wr_req_s[0] && !rd_req_s[1] && !wr_req_s[1],
              "R11 requests low in reset", rd_req_s[0], 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!tx_valid_s[0] && !rd_req_s[0] && !wr_req_s[0], "R11 idle after reset", tx_valid_s[0], 0);

        // R1 / R7 / R8: read with latency 2
        lat = 2; dA = 32'h1111AAAA; dB = 32'h2222BBBB; clr_cycles();
        push_str(0, hexs(dB), "R7 R8 read data next cycle");
        push_str(1, hexs(dA), "R7 R8 read data same cycle");
        send_line("12\n");
        drain();
        check(raddr_seen[0] == 32'h12 && raddr_seen[1] == 32'h12, "R1 read address", raddr_seen[0], 32'h12);
        check(rd_cyc[0] == lat + 1, "R5 read request held until ready", rd_cyc[0], lat + 1);

        // R2 / R8: write
        lat = 0; clr_cycles();
        push_str(2, "ok\n", "R8 write reply");
        send_line("12 deadbeef\n");
        drain();
        check(waddr_seen[0] == 32'h12, "R2 write address", waddr_seen[0], 32'h12);
        check(wdata_seen[0] == 32'hDEADBEEF && wdata_seen[1] == 32'hDEADBEEF, "R2 write data",
              wdata_seen[0], 32'hDEADBEEF);
        check(wr_cyc[0] == 1, "R5 write request dropped after ready", wr_cyc[0], 1);

        // R3: mixed case and truncation
        lat = 1;
        push_str(2, "ok\n", "R3 write reply");
        send_line("aBcD 1234567890\n");
        drain();
        check(waddr_seen[0] == 32'h0000ABCD, "R3 mixed case address", waddr_seen[0], 32'hABCD);
        check(wdata_seen[0] == 32'h34567890, "R3 truncated data", wdata_seen[0], 32'h34567890);

        // R4: invalid, empty, too many tokens
        r0 = rd_txn[0]; w0 = wr_txn[0];
        push_str(2, "error\n", "R4 bad char");
        send_line("7x\n"); drain();
        push_str(2, "error\n", "R4 empty line");
        send_line("\n"); drain();
        push_str(2, "error\n", "R4 three tokens");
        send_line("1 2 3\n"); drain();
        check(rd_txn[0] == r0 && wr_txn[0] == w0, "R4 no bus transaction on error",
              rd_txn[0] + wr_txn[0], r0 + w0);

        // R3: carriage return acts as separator
        lat = 3; dA = 32'h0000CAFE; dB = 32'h00FACE00;
        push_str(0, hexs(dB), "R3 CR line read");
        push_str(1, hexs(dA), "R3 CR line read");
        send_line("5\r\n"); drain();
        check(raddr_seen[0] == 32'h5, "R3 CR read address", raddr_seen[0], 5);

        // R6: timeouts on both directions
        noack = 1'b1; clr_cycles();
        push_str(2, "timeout\n", "R6 read timeout");
        send_line("9\n"); drain();
        check(rd_cyc[0] == RDW && rd_cyc[1] == RDW, "R6 read window length", rd_cyc[0], RDW);
        push_str(2, "timeout\n", "R6 write timeout");
        send_line("9 1\n"); drain();
        check(wr_cyc[0] == WRW, "R6 write window length", wr_cyc[0], WRW);

        // R6: ready on the last allowed cycle wins over expiry
        noack = 1'b0; lat = RDW - 1; dA = 32'h0000_0A0A; dB = 32'h0000_0B0B;
        push_str(0, hexs(dB), "R6 ready in last read cycle");
        push_str(1, hexs(dA), "R6 ready in last read cycle");
        send_line("3\n"); drain();
        lat = WRW - 1;
        push_str(2, "ok\n", "R6 ready in last write cycle");
        send_line("4 55\n"); drain();

        // R9: backpressure during a read reply
        lat = 1; dA = 32'h89ABCDEF; dB = 32'h01234567;
        push_str(0, hexs(dB), "R9 read under backpressure");
        push_str(1, hexs(dA), "R9 read under backpressure");
        toggle_ready = 1'b1;
        send_line("77\n"); drain();
        toggle_ready = 1'b0; tx_ready = 1'b1;

        // R10: bytes during a command are dropped
        lat = 6; dA = 32'h00000040; dB = 32'h00000400;
        r0 = rd_txn[0]; w0 = wr_txn[0];
        push_str(0, hexs(dB), "R10 first read");
        push_str(1, hexs(dA), "R10 first read");
        send_line("40\n");
        send_line("zz\n");
        send_line("8 9\n");
        drain();
        dA = 32'h00000041; dB = 32'h00000410;
        push_str(0, hexs(dB), "R10 next read accepted");
        push_str(1, hexs(dA), "R10 next read accepted");
        send_line("41\n"); drain();
        check(rd_txn[0] == r0 + 2 && wr_txn[0] == w0, "R10 only two reads issued", rd_txn[0], r0 + 2);
        check(raddr_seen[0] == 32'h41, "R10 last read address", raddr_seen[0], 32'h41);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(10 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule